// File: doc/BRIEF.md
# Fault Interrupt and Capture Unit for an Address Translator

This block gathers the fault events of an address translation unit and turns them into one interrupt line that software can service. Five one-cycle event inputs each set a pending bit, and software clears a pending bit by writing 1 to it. A per-event enable mask decides which pending bits may raise the interrupt. The first fault also freezes a snapshot of its details: the virtual address, the ID of the requesting master, a read/write flag and the access kind. The snapshot stays put until software acknowledges it.

The block also holds a small control register. Its enable bits drive the translator's MMU enable, table-walk enable and emulator TLB-update enable. A soft reset command runs a fixed-length internal reset and then raises a reset-done flag. Software reaches the block through a plain 32-bit register port. Writes take effect at the clock edge and reads are combinational. The register map uses word addresses 0 to 6.

Top module: `mmu_fault_irq_unit`

## Requirements
- R1: Pending register (address 0): bit 4 multiple-hit, bit 3 table-walk error, bit 2 emulator miss, bit 1 translation fault, bit 0 TLB miss. A pulse on `evt_in[i]` sets bit i at the next edge. Bits 31:5 read 0.
- R2: Writing 1 to a pending bit clears it and writing 0 leaves it unchanged. If an event and a clear hit the same bit in the same cycle, the bit stays set.
- R3: The enable register (address 1) has the same layout. `irq` equals the OR of (pending AND enable), delayed by one register stage.
- R4: If the acknowledge bit is 0 when any event pulses, the block captures the address into register 3. It captures into register 4 the acknowledge bit (bit 0, set to 1), the rw flag (bit 1), the kind (bits 3:2) and the master ID (bits 7:4, where 8 means hardware walk).
- R5: While the acknowledge bit is 1, later events still set pending bits but leave registers 3 and 4 unchanged.
- R6: Writing 1 to bit 0 of register 4 clears the acknowledge bit and keeps the captured details. Writing 0 has no effect. An event in the same cycle as the clear is captured.
- R7: In the control register (address 2), bit 1 is MMU enable, bit 2 is walk enable and bit 3 is emulator update enable. These bits are read/write and drive `mmu_en`, `walk_en` and `emu_upd_en`. Bit 0 reads 0.
- R8: Writing 1 to bit 0 of address 5 starts an internal reset. That bit always reads 0. The reset clears the pending, enable, control and capture state, and drops `irq`.
- R9: Bit 0 of address 6 (reset done) reads 0 for the 4 cycles of internal reset and the cycle after them, then reads 1. Writes and events are ignored while the internal reset runs. Hardware reset runs the same sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data |
| evt_in | input | 5 | Fault event pulses |
| fault_va | input | 32 | Virtual address of the faulting access |
| fault_mid | input | 4 | Master ID of the faulting access |
| fault_rw | input | 1 | Read/write flag of the faulting access |
| fault_kind | input | 2 | Access kind: 0 data, 1 fetch, 2 DMA |
| irq | output | 1 | Interrupt request |
| mmu_en | output | 1 | MMU enable |
| walk_en | output | 1 | Table-walk enable |
| emu_upd_en | output | 1 | Emulator TLB update enable |

## Verification
A corrupted pending bit appears on the very next read of address 0, and on `irq` one edge later whenever its enable is set. The bench crosses every enable mask with every event pattern, so any pending, enable or OR error shows within two cycles of the pulse. A capture slip, meaning a snapshot that is overwritten or never taken, shows in registers 3 and 4 on the read right after the second fault. A wrong reset counter moves the reset-done edge away from the sixth cycle after the soft reset write, and the bench watches every cycle of that window.

// File: rtl/mmu_fic_pkg.sv
package mmu_fic_pkg;
   localparam int ADDR_W = 3;
   localparam logic [ADDR_W-1:0] REG_PEND   = 3'd0;
   localparam logic [ADDR_W-1:0] REG_MASK   = 3'd1;
   localparam logic [ADDR_W-1:0] REG_CTRL   = 3'd2;
   localparam logic [ADDR_W-1:0] REG_FADDR  = 3'd3;
   localparam logic [ADDR_W-1:0] REG_FINFO  = 3'd4;
   localparam logic [ADDR_W-1:0] REG_SYSCMD = 3'd5;
   localparam logic [ADDR_W-1:0] REG_SYSSTA = 3'd6;

   // snapshot field placement inside the info register
   localparam int INFO_ACK_BIT = 0;
   localparam int INFO_RW_BIT  = 1;
   localparam int INFO_KIND_LO = 2;

   typedef enum logic [1:0] {
      KIND_DATA  = 2'd0,
      KIND_FETCH = 2'd1,
      KIND_DMA   = 2'd2
   } access_kind_e;
endpackage

// File: rtl/mmu_fic_reset_seq.sv
module mmu_fic_reset_seq #(
   parameter int RST_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done
);
   localparam int CW = $clog2(RST_CYCLES + 1);
   localparam logic [CW-1:0] LOAD = CW'(RST_CYCLES);

   if (RST_CYCLES < 1) begin : g_bad_len
      $error("RST_CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   assign busy = (cnt_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= LOAD;
         done  <= 1'b0;
      end else begin
         if (start && !busy) begin
            cnt_q <= LOAD;
         end else if (busy) begin
            cnt_q <= cnt_q - 1'b1;
         end
         done <= (cnt_q == '0) && !start;
      end
   end

   assert_busy_not_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !done);
   assert_done_lags_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> !done);
   assert_start_enters_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && !done));
endmodule

// File: rtl/mmu_fic_status_bank.sv
module mmu_fic_status_bank #(
   parameter int N_EVT = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [N_EVT-1:0] evt,
   input  logic             pend_wr,
   input  logic             mask_wr,
   input  logic [N_EVT-1:0] wr_bits,
   output logic [N_EVT-1:0] pend_q,
   output logic [N_EVT-1:0] mask_q,
   output logic             irq_q
);
   if (N_EVT < 1) begin : g_bad_evt
      $error("N_EVT must be at least 1");
   end

   for (genvar i = 0; i < N_EVT; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend_q[i] <= 1'b0;
         end else if (clr) begin
            pend_q[i] <= 1'b0;
         end else if (evt[i]) begin
            pend_q[i] <= 1'b1;
         end else if (pend_wr && wr_bits[i]) begin
            pend_q[i] <= 1'b0;
         end
      end

      assert_evt_sets_R1: assert property (@(posedge clk) disable iff (!rst_n || clr)
         evt[i] |=> pend_q[i]);
      assert_w1c_R2: assert property (@(posedge clk) disable iff (!rst_n || clr)
         (pend_wr && wr_bits[i] && !evt[i]) |=> !pend_q[i]);
      assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n || clr)
         (!evt[i] && !(pend_wr && wr_bits[i])) |=> $stable(pend_q[i]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         irq_q  <= 1'b0;
      end else if (clr) begin
         mask_q <= '0;
         irq_q  <= 1'b0;
      end else begin
         if (mask_wr) begin
            mask_q <= wr_bits;
         end
         irq_q <= |(pend_q & mask_q);
      end
   end

   assert_irq_on_R3: assert property (@(posedge clk) disable iff (!rst_n || clr)
      (|(pend_q & mask_q)) |=> irq_q);
   assert_irq_off_R3: assert property (@(posedge clk) disable iff (!rst_n || clr)
      !(|(pend_q & mask_q)) |=> !irq_q);
endmodule

// File: rtl/mmu_fic_capture.sv
module mmu_fic_capture #(
   parameter int VA_W   = 32,
   parameter int MID_W  = 4,
   parameter int KIND_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              fault_any,
   input  logic [VA_W-1:0]   va_in,
   input  logic [MID_W-1:0]  mid_in,
   input  logic              rw_in,
   input  logic [KIND_W-1:0] kind_in,
   input  logic              ack_clr,
   output logic              ack_q,
   output logic [VA_W-1:0]   va_q,
   output logic [MID_W-1:0]  mid_q,
   output logic              rw_q,
   output logic [KIND_W-1:0] kind_q
);
   if (VA_W < 1 || MID_W < 1 || KIND_W < 1) begin : g_bad_w
      $error("capture field widths must be positive");
   end

   logic take;
   assign take = fault_any && (!ack_q || ack_clr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q  <= 1'b0;
         va_q   <= '0;
         mid_q  <= '0;
         rw_q   <= 1'b0;
         kind_q <= '0;
      end else if (clr) begin
         ack_q  <= 1'b0;
         va_q   <= '0;
         mid_q  <= '0;
         rw_q   <= 1'b0;
         kind_q <= '0;
      end else if (take) begin
         ack_q  <= 1'b1;
         va_q   <= va_in;
         mid_q  <= mid_in;
         rw_q   <= rw_in;
         kind_q <= kind_in;
      end else if (ack_clr) begin
         ack_q  <= 1'b0;
      end
   end

   assert_first_capture_R4: assert property (@(posedge clk) disable iff (!rst_n || clr)
      (fault_any && !ack_q) |=> (ack_q && va_q == $past(va_in) && mid_q == $past(mid_in)));
   assert_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n || clr)
      (ack_q && !ack_clr) |=> (ack_q && $stable(va_q) && $stable(mid_q)
                               && $stable(rw_q) && $stable(kind_q)));
   assert_ack_clear_R6: assert property (@(posedge clk) disable iff (!rst_n || clr)
      (ack_q && ack_clr && !fault_any) |=> (!ack_q && $stable(va_q)));
endmodule

// File: rtl/mmu_fault_irq_unit.sv
module mmu_fault_irq_unit
   import mmu_fic_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int N_EVT      = 5,
   parameter int VA_W       = 32,
   parameter int MID_W      = 4,
   parameter int KIND_W     = 2,
   parameter int RST_CYCLES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        reg_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic [N_EVT-1:0]  evt_in,
   input  logic [VA_W-1:0]   fault_va,
   input  logic [MID_W-1:0]  fault_mid,
   input  logic              fault_rw,
   input  logic [KIND_W-1:0] fault_kind,
   output logic              irq,
   output logic              mmu_en,
   output logic              walk_en,
   output logic              emu_upd_en
);
   localparam int MID_LO    = INFO_KIND_LO + KIND_W;
   localparam int INFO_W    = MID_LO + MID_W;
   localparam int CTRL_LO   = 1;
   localparam int CTRL_BITS = 3;

   if (DATA_W < VA_W || DATA_W < INFO_W || DATA_W < N_EVT || DATA_W < CTRL_LO + CTRL_BITS) begin : g_bad_data
      $error("DATA_W too narrow for the register fields");
   end

   logic busy, done;
   logic wr_ok;
   logic [N_EVT-1:0] evt_ok;
   logic sys_start;
   logic [N_EVT-1:0] pend_q, mask_q;
   logic ack_q, rw_q;
   logic [VA_W-1:0] va_q;
   logic [MID_W-1:0] mid_q;
   logic [KIND_W-1:0] kind_q;
   logic [CTRL_BITS-1:0] ctrl_q;
   logic wr_unused;

   assign wr_unused = ^wr_data;
   assign wr_ok     = wr_en && !busy;
   assign evt_ok    = busy ? '0 : evt_in;
   assign sys_start = wr_ok && (reg_addr == REG_SYSCMD) && wr_data[0];

   mmu_fic_reset_seq #(.RST_CYCLES(RST_CYCLES)) u_rst (
      .clk   (clk),
      .rst_n (rst_n),
      .start (sys_start),
      .busy  (busy),
      .done  (done)
   );

   mmu_fic_status_bank #(.N_EVT(N_EVT)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (busy),
      .evt     (evt_ok),
      .pend_wr (wr_ok && reg_addr == REG_PEND),
      .mask_wr (wr_ok && reg_addr == REG_MASK),
      .wr_bits (wr_data[N_EVT-1:0]),
      .pend_q  (pend_q),
      .mask_q  (mask_q),
      .irq_q   (irq)
   );

   mmu_fic_capture #(.VA_W(VA_W), .MID_W(MID_W), .KIND_W(KIND_W)) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (busy),
      .fault_any (|evt_ok),
      .va_in     (fault_va),
      .mid_in    (fault_mid),
      .rw_in     (fault_rw),
      .kind_in   (fault_kind),
      .ack_clr   (wr_ok && reg_addr == REG_FINFO && wr_data[INFO_ACK_BIT]),
      .ack_q     (ack_q),
      .va_q      (va_q),
      .mid_q     (mid_q),
      .rw_q      (rw_q),
      .kind_q    (kind_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (busy) begin
         ctrl_q <= '0;
      end else if (wr_ok && reg_addr == REG_CTRL) begin
         ctrl_q <= wr_data[CTRL_LO +: CTRL_BITS];
      end
   end

   assign mmu_en     = ctrl_q[0];
   assign walk_en    = ctrl_q[1];
   assign emu_upd_en = ctrl_q[2];

   always_comb begin
      rd_data = '0;
      case (reg_addr)
         REG_PEND:   rd_data[N_EVT-1:0] = pend_q;
         REG_MASK:   rd_data[N_EVT-1:0] = mask_q;
         REG_CTRL:   rd_data[CTRL_LO +: CTRL_BITS] = ctrl_q;
         REG_FADDR:  rd_data[VA_W-1:0] = va_q;
         REG_FINFO: begin
            rd_data[INFO_ACK_BIT]           = ack_q;
            rd_data[INFO_RW_BIT]            = rw_q;
            rd_data[INFO_KIND_LO +: KIND_W] = kind_q;
            rd_data[MID_LO +: MID_W]        = mid_q;
         end
         REG_SYSSTA: rd_data[0] = done;
         default:    rd_data = '0;
      endcase
   end

   assert_ctrl_bit0_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == REG_CTRL) |-> !rd_data[0]);
   assert_cmd_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == REG_SYSCMD) |-> (rd_data == '0));
   assert_busy_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (!irq && ctrl_q == '0));
endmodule

// File: tb/mmu_fault_irq_unit_tb.sv
module mmu_fault_irq_unit_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic [4:0]  evt_in = '0;
   logic [31:0] fault_va = '0;
   logic [3:0]  fault_mid = '0;
   logic        fault_rw = 1'b0;
   logic [1:0]  fault_kind = '0;
   logic        irq, mmu_en, walk_en, emu_upd_en;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mmu_fault_irq_unit u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
      .wr_data(wr_data), .rd_data(rd_data), .evt_in(evt_in),
      .fault_va(fault_va), .fault_mid(fault_mid), .fault_rw(fault_rw),
      .fault_kind(fault_kind), .irq(irq), .mmu_en(mmu_en),
      .walk_en(walk_en), .emu_upd_en(emu_upd_en)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic rdchk(input logic [2:0] a, input logic [31:0] exp, input string tag);
      wr_en = 1'b0;
      reg_addr = a;
      #1;
      chk(tag, rd_data, exp);
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; reg_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic pulse(input logic [4:0] e, input logic [31:0] va, input logic [3:0] mid,
                        input logic rw, input logic [1:0] kind);
      @(negedge clk);
      evt_in = e; fault_va = va; fault_mid = mid; fault_rw = rw; fault_kind = kind;
      @(negedge clk);
      evt_in = '0;
   endtask

   function automatic logic [31:0] info(input logic [3:0] mid, input logic [1:0] kind,
                                        input logic rw, input logic ack);
      return {24'd0, mid, kind, rw, ack};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      rdchk(3'd6, 32'h0, "R9 reset-done low right after reset");
      repeat (6) @(negedge clk);
      rdchk(3'd6, 32'h1, "R9 reset-done high after sequence");
      rdchk(3'd0, 32'h0, "R1 pending reset value");
      rdchk(3'd1, 32'h0, "R3 mask reset value");
      rdchk(3'd2, 32'h0, "R7 control reset value");
      rdchk(3'd4, 32'h0, "R4 info reset value");
      chk("R3 irq reset value", {31'd0, irq}, 32'h0);

      // R1 R3 R4: every enable mask crossed with every event pattern
      for (int m = 0; m < 32; m++) begin
         wr(3'd1, m);
         for (int p = 0; p < 32; p++) begin
            pulse(p[4:0], {m[15:0], p[15:0]}, p[3:0], p[0], 2'(m % 3));
            rdchk(3'd0, p, "R1 pending after pulse");
            if (p != 0) begin
               rdchk(3'd3, {m[15:0], p[15:0]}, "R4 captured address");
               rdchk(3'd4, info(p[3:0], 2'(m % 3), p[0], 1'b1), "R4 captured info");
            end
            @(negedge clk);
            chk("R3 irq follows enabled pending", {31'd0, irq}, {31'd0, |(p[4:0] & m[4:0])});
            wr(3'd0, 32'h1f);
            wr(3'd4, 32'h1);
            chk("R3 irq drops after clear", {31'd0, irq}, 32'h0);
         end
      end
      wr(3'd1, 32'h0);

      // R4 R5 R6 first-fault freeze
      pulse(5'b00010, 32'hAAAA_0001, 4'd8, 1'b1, 2'd2);
      rdchk(3'd4, 32'h8B, "R4 hardware-walk master captured");
      pulse(5'b10000, 32'hBBBB_0002, 4'd3, 1'b0, 2'd1);
      rdchk(3'd0, 32'h12, "R5 later fault still sets pending");
      rdchk(3'd3, 32'hAAAA_0001, "R5 address frozen");
      rdchk(3'd4, 32'h8B, "R5 info frozen");
      wr(3'd4, 32'h0);
      rdchk(3'd4, 32'h8B, "R6 write 0 keeps acknowledge");
      wr(3'd4, 32'h1);
      rdchk(3'd4, 32'h8A, "R6 acknowledge cleared, details kept");
      rdchk(3'd3, 32'hAAAA_0001, "R6 address kept after clear");
      pulse(5'b00001, 32'hCCCC_0003, 4'd5, 1'b0, 2'd0);
      rdchk(3'd4, 32'h51, "R4 new capture after clear");
      rdchk(3'd3, 32'hCCCC_0003, "R4 new address after clear");

      // R2 partial clear, zero write, and set-wins collision
      wr(3'd0, 32'h0);
      rdchk(3'd0, 32'h13, "R2 write 0 keeps pending");
      wr(3'd0, 32'h02);
      rdchk(3'd0, 32'h11, "R2 partial clear");
      @(negedge clk);
      wr_en = 1'b1; reg_addr = 3'd0; wr_data = 32'h1f; evt_in = 5'b00100;
      @(negedge clk);
      wr_en = 1'b0; evt_in = '0;
      rdchk(3'd0, 32'h04, "R2 event wins over same-cycle clear");
      wr(3'd0, 32'h1f);
      wr(3'd4, 32'h1);

      // R7 control
      wr(3'd2, 32'hFFFF_FFFF);
      rdchk(3'd2, 32'hE, "R7 control bits, bit0 zero");
      chk("R7 enable outputs", {29'd0, emu_upd_en, walk_en, mmu_en}, 32'h7);
      wr(3'd2, 32'h4);
      rdchk(3'd2, 32'h4, "R7 walk only");
      chk("R7 walk only outputs", {29'd0, emu_upd_en, walk_en, mmu_en}, 32'h2);
      wr(3'd2, 32'hE);

      // R8 R9 soft reset
      wr(3'd1, 32'h1f);
      pulse(5'b00011, 32'h1234_5678, 4'd2, 1'b1, 2'd1);
      @(negedge clk);
      chk("R3 irq before soft reset", {31'd0, irq}, 32'h1);
      wr(3'd5, 32'h1);
      rdchk(3'd5, 32'h0, "R8 command bit reads 0");
      rdchk(3'd6, 32'h0, "R9 done low cycle 0");
      wr_en = 1'b1; reg_addr = 3'd1; wr_data = 32'h5; evt_in = 5'b11111;
      @(negedge clk);
      wr_en = 1'b0; evt_in = '0;
      rdchk(3'd6, 32'h0, "R9 done low cycle 1");
      for (int j = 2; j <= 4; j++) begin
         @(negedge clk);
         rdchk(3'd6, 32'h0, "R9 done low during reset");
      end
      @(negedge clk);
      rdchk(3'd6, 32'h1, "R9 done rises after reset");
      rdchk(3'd0, 32'h0, "R8 pending cleared, R9 busy events ignored");
      rdchk(3'd1, 32'h0, "R8 mask cleared, R9 busy write ignored");
      rdchk(3'd2, 32'h0, "R8 control cleared");
      rdchk(3'd4, 32'h0, "R8 info cleared");
      rdchk(3'd3, 32'h0, "R8 address cleared");
      chk("R8 irq low after reset", {31'd0, irq}, 32'h0);
      chk("R8 enable outputs low", {29'd0, emu_upd_en, walk_en, mmu_en}, 32'h0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule